// File: doc/BRIEF.md
# Serial EEPROM byte-access master

This block is a two-wire bus master that runs on the system clock. It carries out single-byte random writes and random reads to a small serial EEPROM. A command port accepts a request strobe along with a direction flag, a 3-bit chip select, an 8-bit memory address, an 8-bit write byte and a flag that enables completion polling. The block returns the byte read, a one-cycle done strobe and an error flag.

The block drives the clock line directly. It controls the data line in open-drain fashion, through an output enable that pulls the line low and an input that reads the line back. Every bus action is built from quarter periods of the serial clock. The length of a quarter comes from a divider parameter, so one SCL half period lasts two quarters.

Each transfer follows a fixed script:
- A read always begins with a dummy write of the address, followed by a repeated START.
- Any missing acknowledge ends the transfer with a STOP and raises the error flag.
- After a write, optional acknowledge polling waits until the device has finished its internal programming cycle.

Top module: `eeprom_byte_master`

## Requirements
- R1: After reset, and whenever no transfer is running, SCL is high, SDA is released (`sda_oe_o` = 0), `done_o` is 0 and, after reset, `err_o` is 0.
- R2: A write (`rw_i` = 0) sends START, then the control byte, the memory address and the data byte, each followed by an acknowledge clock, then STOP. The control byte is 4'b1010 in bits 7..4, the chip select in bits 3..1 and the direction in bit 0 (0 = write, 1 = read). Bytes go out MSB first. The device then holds the byte at that address. A write without polling produces exactly 28 SCL rising edges.
- R3: While SCL is low, SDA changes exactly QTR_CYCLES clock cycles after SCL falls. SDA never changes on the cycle in which SCL rises or falls. While SCL is high, SDA changes only as a START (falling) or a STOP (rising).
- R4: A read (`rw_i` = 1) sends START, the control byte for a write, the address, a repeated START, the control byte for a read, eight data clocks, a NACK clock and STOP. It produces exactly 38 SCL rising edges, and `rdata_o` then holds the received byte (MSB first).
- R5: If an expected acknowledge is missing (SDA high on the ninth clock), no further byte is sent, a STOP follows and `err_o` is set. A NACK of the first control byte gives 10 SCL rising edges in total.
- R6: With `poll_i` = 1, a successful write STOP is followed by attempts of START, control byte (write), acknowledge clock and STOP. Attempts repeat until one is acknowledged, and each attempt adds 10 SCL rising edges. The transfer then ends without error.
- R7: If POLL_MAX polling attempts are all refused, the transfer ends with `err_o` set.
- R8: A request that arrives while a transfer is running is ignored. It starts nothing and changes neither the running transfer nor the number of done strobes.
- R9: `done_o` is high for exactly one cycle at the end of every accepted request, whether it succeeded or was aborted. `err_o` is valid in that cycle and holds until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Command strobe, taken only while idle |
| rw_i | input | 1 | 1 = read, 0 = write |
| cs_i | input | 3 | Chip-select bits placed in the control byte |
| addr_i | input | 8 | Memory address inside the device |
| wdata_i | input | 8 | Byte to write |
| poll_i | input | 1 | Poll for write completion after a write |
| rdata_o | output | 8 | Byte returned by the last read |
| done_o | output | 1 | One-cycle end-of-transfer strobe |
| err_o | output | 1 | Missing acknowledge or polling timeout |
| scl_o | output | 1 | Serial clock line |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| sda_i | input | 1 | Data line as seen on the bus |

## Verification
The hardest situations to reach are the polling ones. A device that refuses several attempts and then accepts one, and a device that never accepts within POLL_MAX tries, both need a bus partner that stays busy on purpose. The bench's device model therefore holds a configurable count of refusals, which it arms at each write STOP. A forced NACK on a chosen byte index covers aborts after the control byte has already been acknowledged. Counting SCL rising edges on every transfer then shows whether the script stopped at the right point.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [1:0] {
    SYM_START,
    SYM_RSTART,
    SYM_BIT,
    SYM_STOP
  } sym_e;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_START,
    PH_CTRLW,
    PH_MADDR,
    PH_WDATA,
    PH_RSTART,
    PH_CTRLR,
    PH_RDATA,
    PH_STOP,
    PH_PSTART,
    PH_PCTRL
  } phase_e;
endpackage

// File: rtl/eep_qtick.sv
module eep_qtick #(
  parameter int QTR_CYCLES = 312
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int CW = (QTR_CYCLES < 2) ? 1 : $clog2(QTR_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr || !run) cnt <= '0;
    else if (cnt == LAST)   cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/eep_sym_engine.sv
module eep_sym_engine
  import eep_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  sym_e kind,
  input  logic txbit,
  input  logic tick,
  input  logic sda_i,
  output logic busy,
  output logic done,
  output logic rxbit,
  output logic scl_o,
  output logic sda_oe_o
);
  logic [1:0] q;
  sym_e       kind_r;
  logic       bit_r;
  logic       scl_r, oe_r;
  logic [1:0] sync;

  // {scl, oe} for a symbol in a given quarter; SCL high in quarters 2..3
  function automatic logic [1:0] drive_of(sym_e k, logic [1:0] qq, logic b, logic oe_now);
    logic scl_n, oe_n;
    scl_n = qq[1];
    oe_n  = oe_now;
    case (k)
      SYM_START:  begin scl_n = 1'b1; oe_n = qq[1]; end
      SYM_RSTART: begin if (qq != 2'd0) oe_n = (qq == 2'd3); end
      SYM_BIT:    begin if (qq != 2'd0) oe_n = ~b; end
      SYM_STOP:   begin if (qq != 2'd0) oe_n = (qq != 2'd3); end
      default:    ;
    endcase
    return {scl_n, oe_n};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else     sync <= {sync[0], sda_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      q      <= 2'd0;
      kind_r <= SYM_START;
      bit_r  <= 1'b0;
      scl_r  <= 1'b1;
      oe_r   <= 1'b0;
      done   <= 1'b0;
      rxbit  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        busy          <= 1'b1;
        q             <= 2'd0;
        kind_r        <= kind;
        bit_r         <= txbit;
        {scl_r, oe_r} <= drive_of(kind, 2'd0, txbit, oe_r);
      end else if (busy && tick) begin
        if (q == 2'd2) rxbit <= sync[1];
        if (q == 2'd3) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          q             <= q + 2'd1;
          {scl_r, oe_r} <= drive_of(kind_r, q + 2'd1, bit_r, oe_r);
        end
      end
    end
  end

  assign scl_o    = scl_r;
  assign sda_oe_o = oe_r;

  // SDA must hold on both SCL edges
  p_sda_hold_fall_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_r) |-> $stable(oe_r));
  p_sda_hold_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_r) |-> $stable(oe_r));
  // data bits never move SDA while SCL stays high
  p_bit_no_high_change_r3: assert property (@(posedge clk) disable iff (rst)
    (scl_r && $past(scl_r) && !$stable(oe_r)) |-> (kind_r != SYM_BIT));
endmodule

// File: rtl/eep_seq.sv
module eep_seq
  import eep_pkg::*;
#(
  parameter int POLL_MAX = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              rw_i,
  input  logic [2:0]        cs_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              poll_i,
  input  logic              sym_done,
  input  logic              rxbit,
  output logic              sym_go,
  output sym_e              sym_kind,
  output logic              sym_bit,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int PW = (POLL_MAX < 2) ? 1 : $clog2(POLL_MAX);
  localparam logic [PW-1:0] PLAST = PW'(POLL_MAX - 1);
  localparam logic [3:0] ACK_SLOT = 4'(BYTE_W);

  phase_e            phase;
  logic              pend;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] sh;
  logic              rw_r, poll_r, ppend;
  logic [2:0]        cs_r;
  logic [BYTE_W-1:0] addr_r, wd_r;
  logic [PW-1:0]     pcnt;
  logic              is_byte;

  function automatic logic [BYTE_W-1:0] ctrl_of(logic [2:0] cs, logic rd);
    return {DEV_TYPE, cs, rd};
  endfunction

  always_comb begin
    is_byte = (phase == PH_CTRLW) || (phase == PH_MADDR) || (phase == PH_WDATA) ||
              (phase == PH_CTRLR) || (phase == PH_RDATA) || (phase == PH_PCTRL);
    sym_bit = 1'b1;
    case (phase)
      PH_START, PH_PSTART: sym_kind = SYM_START;
      PH_RSTART:           sym_kind = SYM_RSTART;
      PH_STOP:             sym_kind = SYM_STOP;
      default: begin
        sym_kind = SYM_BIT;
        if (is_byte && bitcnt != ACK_SLOT && phase != PH_RDATA) sym_bit = sh[BYTE_W-1];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      pend    <= 1'b0;
      bitcnt  <= '0;
      sh      <= '0;
      rw_r    <= 1'b0;
      poll_r  <= 1'b0;
      ppend   <= 1'b0;
      cs_r    <= '0;
      addr_r  <= '0;
      wd_r    <= '0;
      pcnt    <= '0;
      sym_go  <= 1'b0;
      rdata_o <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      sym_go <= 1'b0;
      done_o <= 1'b0;
      if (phase == PH_IDLE) begin
        if (req_i) begin
          rw_r   <= rw_i;
          cs_r   <= cs_i;
          addr_r <= addr_i;
          wd_r   <= wdata_i;
          poll_r <= poll_i;
          err_o  <= 1'b0;
          ppend  <= 1'b0;
          pcnt   <= '0;
          pend   <= 1'b0;
          bitcnt <= '0;
          phase  <= PH_START;
        end
      end else if (!pend) begin
        sym_go <= 1'b1;
        pend   <= 1'b1;
      end else if (sym_done) begin
        pend <= 1'b0;
        if (is_byte && bitcnt != ACK_SLOT) begin
          bitcnt <= bitcnt + 4'd1;
          sh     <= {sh[BYTE_W-2:0], rxbit};
        end else begin
          bitcnt <= '0;
          case (phase)
            PH_START:  begin phase <= PH_CTRLW; sh <= ctrl_of(cs_r, 1'b0); end
            PH_PSTART: begin phase <= PH_PCTRL; sh <= ctrl_of(cs_r, 1'b0); end
            PH_RSTART: begin phase <= PH_CTRLR; sh <= ctrl_of(cs_r, 1'b1); end
            PH_CTRLW: begin
              if (rxbit) begin err_o <= 1'b1; phase <= PH_STOP; end
              else begin phase <= PH_MADDR; sh <= addr_r; end
            end
            PH_MADDR: begin
              if (rxbit)     begin err_o <= 1'b1; phase <= PH_STOP; end
              else if (rw_r) phase <= PH_RSTART;
              else begin phase <= PH_WDATA; sh <= wd_r; end
            end
            PH_WDATA: begin
              if (rxbit) err_o <= 1'b1;
              else       ppend <= poll_r;
              phase <= PH_STOP;
            end
            PH_CTRLR: begin
              if (rxbit) begin err_o <= 1'b1; phase <= PH_STOP; end
              else phase <= PH_RDATA;
            end
            PH_RDATA: begin rdata_o <= sh; phase <= PH_STOP; end
            PH_PCTRL: begin
              if (!rxbit) ppend <= 1'b0;
              else if (pcnt == PLAST) begin ppend <= 1'b0; err_o <= 1'b1; end
              else pcnt <= pcnt + 1'b1;
              phase <= PH_STOP;
            end
            PH_STOP: begin
              if (ppend) phase <= PH_PSTART;
              else begin done_o <= 1'b1; phase <= PH_IDLE; end
            end
            default: phase <= PH_IDLE;
          endcase
        end
      end
    end
  end

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_err_held_r9: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && !req_i) |=> $stable(err_o));
  p_cmd_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |=> ($stable(addr_r) && $stable(cs_r) && $stable(rw_r)));
endmodule

// File: rtl/eeprom_byte_master.sv
module eeprom_byte_master
  import eep_pkg::*;
#(
  parameter int QTR_CYCLES = 312,
  parameter int POLL_MAX   = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_i,
  input  logic        rw_i,
  input  logic [2:0]  cs_i,
  input  logic [7:0]  addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        poll_i,
  output logic [7:0]  rdata_o,
  output logic        done_o,
  output logic        err_o,
  output logic        scl_o,
  output logic        sda_oe_o,
  input  logic        sda_i
);
  logic sym_go, sym_bit, sym_done, rxbit, eng_busy, tick;
  sym_e sym_kind;

  eep_qtick #(.QTR_CYCLES(QTR_CYCLES)) u_tick (
    .clk(clk), .rst(rst), .run(eng_busy), .clr(sym_go), .tick(tick)
  );

  eep_sym_engine u_eng (
    .clk(clk), .rst(rst), .go(sym_go), .kind(sym_kind), .txbit(sym_bit),
    .tick(tick), .sda_i(sda_i), .busy(eng_busy), .done(sym_done),
    .rxbit(rxbit), .scl_o(scl_o), .sda_oe_o(sda_oe_o)
  );

  eep_seq #(.POLL_MAX(POLL_MAX)) u_seq (
    .clk(clk), .rst(rst), .req_i(req_i), .rw_i(rw_i), .cs_i(cs_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .poll_i(poll_i),
    .sym_done(sym_done), .rxbit(rxbit), .sym_go(sym_go),
    .sym_kind(sym_kind), .sym_bit(sym_bit), .rdata_o(rdata_o),
    .done_o(done_o), .err_o(err_o)
  );

  p_bus_free_at_done_r1: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (scl_o && !sda_oe_o));
endmodule

// File: tb/sim_eeprom_byte_master.sv
module sim_eeprom_byte_master;
  localparam int QTR = 4;
  localparam int PMAX = 5;
  localparam logic [2:0] DEV_CS = 3'b101;

  logic clk = 1'b0, rst = 1'b1;
  logic req = 1'b0, rw = 1'b0, poll = 1'b0;
  logic [2:0] cs = '0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic done, err, scl, sda_oe, sda_in;
  logic s_drv = 1'b0;

  always #4 clk = ~clk;
  assign sda_in = ~(sda_oe | s_drv);

  eeprom_byte_master #(.QTR_CYCLES(QTR), .POLL_MAX(PMAX)) u0 (
    .clk(clk), .rst(rst), .req_i(req), .rw_i(rw), .cs_i(cs), .addr_i(addr),
    .wdata_i(wdata), .poll_i(poll), .rdata_o(rdata), .done_o(done),
    .err_o(err), .scl_o(scl), .sda_oe_o(sda_oe), .sda_i(sda_in)
  );

  int n_chk = 0, n_bad = 0;
  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // device model and bus monitor
  logic [7:0] mem [256];
  int rises, starts, stops, dones, tbad, fall_cnt;
  int st, bitn, rbn, byte_idx, busy_left, busy_cfg, force_nack;
  logic [7:0] sh, ptr, rb, wbyte, last_ctrl;
  logic wpend, rwf, acked, p_scl, p_sda, p_oe;

  always @(negedge clk) begin
    if (rst) begin
      st = 0; bitn = 0; rbn = 0; wpend = 0; s_drv = 0; busy_left = 0;
      p_scl = 1; p_sda = 1; p_oe = 0; fall_cnt = 0;
    end else begin
      if (done) dones++;
      if (!scl && p_scl) fall_cnt = 0;
      else if (!scl) fall_cnt++;
      if (!scl && !p_scl && sda_oe != p_oe && fall_cnt != QTR) tbad++;
      if (scl && p_scl && p_sda && !sda_in) begin
        starts++; st = 1; bitn = 0; s_drv = 0; byte_idx = 0;
      end else if (scl && p_scl && !p_sda && sda_in) begin
        stops++;
        if (wpend) begin mem[ptr] = wbyte; busy_left = busy_cfg; wpend = 0; end
        st = 0; s_drv = 0;
      end else if (scl && !p_scl) begin
        rises++;
        if (st == 4) rbn++;
        else if (st != 0 && bitn < 8) begin sh = {sh[6:0], sda_in}; bitn++; end
      end else if (!scl && p_scl) begin
        if (st == 4) begin
          if (rbn < 8) s_drv = !rb[7-rbn];
          else if (rbn == 8) s_drv = 0;
          else st = 0;
        end else if (st != 0 && bitn == 8) begin
          acked = (byte_idx != force_nack);
          if (st == 1) begin
            last_ctrl = sh;
            if (sh[7:1] != {4'b1010, DEV_CS}) acked = 0;
            else if (busy_left > 0) begin busy_left--; acked = 0; end
            rwf = sh[0];
          end else if (st == 2 && acked) ptr = sh;
          else if (st == 3 && acked) begin wbyte = sh; wpend = 1; end
          s_drv = acked; bitn = 9;
        end else if (st != 0 && bitn == 9) begin
          s_drv = 0; bitn = 0; byte_idx++;
          if (!acked) st = 0;
          else if (st == 1) begin
            if (rwf) begin st = 4; rb = mem[ptr]; rbn = 0; s_drv = !rb[7]; end
            else st = 2;
          end else if (st == 2) st = 3;
          else st = 0;
        end
      end
      p_scl = scl; p_sda = sda_in; p_oe = sda_oe;
    end
  end

  logic got_err;
  logic [7:0] got_rd;
  task automatic run_cmd(input logic r, input logic [2:0] c, input logic [7:0] a,
                         input logic [7:0] d, input logic p);
    int n;
    rises = 0; starts = 0; stops = 0; dones = 0; tbad = 0;
    @(negedge clk);
    req = 1; rw = r; cs = c; addr = a; wdata = d; poll = p;
    @(negedge clk);
    req = 0;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk("R9 done seen", int'(done), 1);
    got_err = err; got_rd = rdata;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 scl idle", int'(scl), 1);
    chk("R1 sda released", int'(sda_oe), 0);
    chk("R1 done low", int'(done), 0);
    chk("R1 err low", int'(err), 0);
  endtask

  task automatic t_write;
    mem[8'h3C] = 8'h00;
    run_cmd(0, DEV_CS, 8'h3C, 8'hA5, 0);
    chk("R2 err", int'(got_err), 0);
    chk("R2 rises", rises, 28);
    chk("R2 stored", int'(mem[8'h3C]), 8'hA5);
    chk("R2 ctrl byte", int'(last_ctrl), 8'hAA);
    chk("R3 start/stop", starts * 10 + stops, 11);
    chk("R3 quarter delay", tbad, 0);
    chk("R9 one done", dones, 1);
    chk("R1 idle after", int'(scl && !sda_oe), 1);
  endtask

  task automatic t_read(input logic [7:0] a, input logic [7:0] v);
    mem[a] = v;
    run_cmd(1, DEV_CS, a, 8'h00, 0);
    chk("R4 err", int'(got_err), 0);
    chk("R4 data", int'(got_rd), int'(v));
    chk("R4 rises", rises, 38);
    chk("R4 starts", starts, 2);
    chk("R4 ctrl read", int'(last_ctrl), 8'hAB);
    chk("R3 quarter delay", tbad, 0);
  endtask

  task automatic t_nack_ctrl;
    mem[8'h20] = 8'h11;
    run_cmd(0, 3'b010, 8'h20, 8'h99, 0);
    chk("R5 err", int'(got_err), 1);
    chk("R5 rises", rises, 10);
    chk("R5 stop", stops, 1);
    chk("R5 mem kept", int'(mem[8'h20]), 8'h11);
    repeat (30) @(negedge clk);
    chk("R9 err held", int'(err), 1);
  endtask

  task automatic t_nack_data;
    mem[8'h10] = 8'h55;
    force_nack = 2;
    run_cmd(0, DEV_CS, 8'h10, 8'h66, 0);
    force_nack = -1;
    chk("R5 data nack err", int'(got_err), 1);
    chk("R5 data nack rises", rises, 28);
    chk("R5 data nack mem", int'(mem[8'h10]), 8'h55);
  endtask

  task automatic t_poll;
    busy_cfg = 3;
    run_cmd(0, DEV_CS, 8'h42, 8'h7E, 1);
    busy_cfg = 0;
    chk("R6 err", int'(got_err), 0);
    chk("R6 rises", rises, 68);
    chk("R6 stops", stops, 5);
    chk("R6 stored", int'(mem[8'h42]), 8'h7E);
  endtask

  task automatic t_poll_timeout;
    busy_cfg = 50;
    run_cmd(0, DEV_CS, 8'h43, 8'h01, 1);
    busy_cfg = 0;
    busy_left = 0;
    chk("R7 err", int'(got_err), 1);
    chk("R7 rises", rises, 28 + 10 * PMAX);
    chk("R9 done count", dones, 1);
  endtask

  task automatic t_ignore;
    int n;
    rises = 0; dones = 0;
    @(negedge clk);
    req = 1; rw = 0; cs = DEV_CS; addr = 8'h77; wdata = 8'h3D; poll = 0;
    @(negedge clk);
    req = 0;
    repeat (200) @(negedge clk);
    req = 1; rw = 1; addr = 8'h05;
    @(negedge clk);
    req = 0;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    repeat (600) @(negedge clk);
    chk("R8 one done", dones, 1);
    chk("R8 rises", rises, 28);
    chk("R8 stored", int'(mem[8'h77]), 8'h3D);
    chk("R8 bus idle", int'(scl && !sda_oe), 1);
  endtask

  initial begin
    force_nack = -1; busy_cfg = 0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    t_reset;
    t_write;
    t_read(8'h3C, 8'hA5);
    t_read(8'hFF, 8'h81);
    t_nack_ctrl;
    t_write;
    t_nack_data;
    t_poll;
    t_poll_timeout;
    t_read(8'h00, 8'h3B);
    t_ignore;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule